// File: doc/BRIEF.md
# Page-mode DRAM command decoder

This block is the device side of a 16-bit dynamic memory with asynchronous active-low strobes, sampled on a fast system clock. It watches the row strobe, two byte-lane column strobes, write enable and output enable. From these it classifies each cycle and drives a small on-chip word array. The array is a shrunk stand-in for the full cell matrix and is indexed by the low bits of the latched row and column.

A fall of the row strobe with both column strobes high opens a row from the multiplexed address pins. A fall of the row strobe while either column strobe is already low is a refresh that takes its row from an internal counter. That counter steps after every such refresh, including a hidden refresh that keeps a column strobe low from a preceding read. Within an open row the column strobes may cycle repeatedly for page-mode access. Each byte lane is gated by its own column strobe.

Every refresh, whether the row came from the pins or from the counter, is reported as a one-cycle strobe together with the refreshed row.

Top module: `fpm_dram_dev`

## Requirements
- R1: After reset, `cyc_kind` is 0 (idle), `dq_oe` is 2'b00 and `rfsh_stb` is low.
- R2: A row-strobe fall with both column strobes high latches the row from `addr`. One clock later `rfsh_stb` is high, `rfsh_row` equals that row, and `cyc_kind` is 6 (row-only).
- R3: With write enable low at a column-strobe fall, the lanes whose strobes are low store `dq_in` at the open row and the latched column. Lane 0 is bits 7:0 under `lcas_n` and lane 1 is bits 15:8 under `ucas_n`. `cyc_kind` becomes 2 (write).
- R4: With write enable high at a column-strobe fall, the addressed word is latched to `dq_out`. `dq_oe[i]` is high while lane i's strobe and `oe_n` are both low. `cyc_kind` becomes 1 (read).
- R5: A lane whose column strobe is high is never driven, and `dq_oe[i]` drops as soon as that strobe rises.
- R6: While the row strobe stays low, each later column-strobe fall accesses a new column of the same row. `cyc_kind` becomes 3 (page read) or 4 (page write).
- R7: A fall of write enable while a column strobe is low after a read writes `dq_in` to the same column. `cyc_kind` becomes 5 (read-modify-write).
- R8: A row-strobe fall with a column strobe low is a counter refresh. `cyc_kind` becomes 7, `rfsh_row` equals the counter, and no data is transferred. The counter then increments and wraps at 2^ROW_W, starting from 0 after reset.
- R9: A row-only refresh leaves the refresh counter unchanged, and `cyc_kind` stays 6 after the row strobe rises.
- R10: In a hidden refresh, with the column strobe and `oe_n` held low from a read while the row strobe goes high then low, `dq_out` and `dq_oe` stay valid and the cycle counts as a counter refresh.
- R11: `rfsh_stb` is high for exactly one clock after each row-strobe fall and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the pins |
| dq_out | output | 16 | Read data toward the pins |
| dq_oe | output | 2 | Per-lane output drive enable |
| cyc_kind | output | 3 | Cycle classification code |
| rfsh_stb | output | 1 | One-cycle refresh indication |
| rfsh_row | output | ROW_W | Row refreshed with the strobe |

## Verification
The assertions watch, on every cycle, the properties of the refresh strobe: it appears only after a row-strobe fall and lasts one clock. On each cycle they also check that a row-only refresh reports the row taken from the pins, that a counter refresh leaves the counter one past the reported row, and that a lane with its strobe high is never driven. Only the bench scenarios can show that stored data round-trips through early writes, page-mode reads and byte-lane writes. The same holds for read-modify-write data replacing the read word, for the counter wrapping across repeated refreshes, and for read data surviving a hidden refresh.

// File: rtl/fpm_dram_dev.sv
module fpm_dram_dev #(
  parameter int ROW_W  = 13,
  parameter int ARR_RB = 3,
  parameter int ARR_CB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              ucas_n,
  input  logic              lcas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [1:0]        dq_oe,
  output logic [2:0]        cyc_kind,
  output logic              rfsh_stb,
  output logic [ROW_W-1:0]  rfsh_row
);
  localparam int IW    = ARR_RB + ARR_CB;
  localparam int DEPTH = 1 << IW;
  localparam logic [2:0] K_IDLE = 3'd0, K_RD = 3'd1, K_WR = 3'd2, K_PRD = 3'd3,
                         K_PWR = 3'd4, K_RMW = 3'd5, K_ROR = 3'd6, K_CBR = 3'd7;

  logic [15:0] mem [DEPTH];
  logic [1:0]  cas_n, cas_q, rd_v;
  logic        ras_q, we_q, row_open, paged;
  logic [ARR_RB-1:0] row_q;
  logic [ARR_CB-1:0] col_q;
  logic [ROW_W-1:0]  refcnt;

  assign cas_n = {ucas_n, lcas_n};

  wire       ras_fall   = ras_q & ~ras_n;
  wire       ras_rise   = ~ras_q & ras_n;
  wire [1:0] lane_fall  = cas_q & ~cas_n;
  wire       first_fall = (&cas_q) & ~(&cas_n);
  wire       we_fall    = we_q & ~we_n;
  wire       acc        = row_open & ~ras_n;
  wire       late_we    = acc & we_fall & ~(&cas_n) & ~(|lane_fall);

  wire [ARR_CB-1:0] col_now = first_fall ? addr[ARR_CB-1:0] : col_q;
  wire [IW-1:0]     idx     = {row_q, col_now};

  wire [1:0] wr_lane = acc ? ((lane_fall & {2{~we_n}}) | ({2{late_we}} & ~cas_n)) : 2'b00;
  wire [1:0] rd_lane = acc ? (lane_fall & {2{we_n}}) : 2'b00;

  assign dq_oe = rd_v & ~cas_n & {2{~oe_n}};

  for (genvar i = 0; i < 2; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_lane[i]) mem[idx][i*8 +: 8] <= dq_in[i*8 +: 8];
      if (rd_lane[i]) dq_out[i*8 +: 8] <= mem[idx][i*8 +: 8];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                   rd_v[i] <= 1'b0;
      else if (cas_n[i] || wr_lane[i]) rd_v[i] <= 1'b0;
      else if (rd_lane[i])          rd_v[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 2'b11;
      we_q     <= 1'b1;
      row_open <= 1'b0;
      paged    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      refcnt   <= '0;
      rfsh_stb <= 1'b0;
      rfsh_row <= '0;
      cyc_kind <= K_IDLE;
    end else begin
      ras_q    <= ras_n;
      cas_q    <= cas_n;
      we_q     <= we_n;
      rfsh_stb <= ras_fall;
      if (ras_fall) begin
        if (~&cas_n) begin
          cyc_kind <= K_CBR;
          rfsh_row <= refcnt;
          refcnt   <= refcnt + 1'b1;
        end else begin
          cyc_kind <= K_ROR;
          rfsh_row <= addr;
          row_q    <= addr[ARR_RB-1:0];
          row_open <= 1'b1;
          paged    <= 1'b0;
        end
      end
      if (ras_rise) row_open <= 1'b0;
      if (acc && first_fall) begin
        col_q    <= addr[ARR_CB-1:0];
        paged    <= 1'b1;
        cyc_kind <= paged ? (we_n ? K_PRD : K_PWR) : (we_n ? K_RD : K_WR);
      end else if (late_we) begin
        cyc_kind <= K_RMW;
      end
    end
  end
endmodule

module fpm_dram_dev_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             ucas_n,
  input logic             lcas_n,
  input logic [ROW_W-1:0] addr,
  input logic [1:0]       dq_oe,
  input logic [2:0]       cyc_kind,
  input logic             rfsh_stb,
  input logic [ROW_W-1:0] rfsh_row,
  input logic [ROW_W-1:0] refcnt
);
  p_ror_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && cyc_kind == 3'd6) |-> rfsh_row == $past(addr));

  p_lane_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ucas_n || lcas_n) |-> !(ucas_n && dq_oe[1]) && !(lcas_n && dq_oe[0]));

  p_cbr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_stb && cyc_kind == 3'd7) |-> refcnt == ROW_W'(rfsh_row + 1'b1));

  p_stb_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |-> (!$past(ras_n) && $past(ras_n, 2)));

  p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |=> !rfsh_stb);
endmodule

bind fpm_dram_dev fpm_dram_dev_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/fpm_dram_dev_bench.sv
module fpm_dram_dev_bench;
  localparam int RW = 4, RB = 4, CB = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, ucas_n = 1, lcas_n = 1, we_n = 1, oe_n = 1;
  logic [RW-1:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0] dq_oe;
  logic [2:0] cyc_kind;
  logic rfsh_stb;
  logic [RW-1:0] rfsh_row;

  int checks = 0, errors = 0, exp_ref = 0;
  logic [15:0] model [0:127];

  always #2.5 clk = ~clk;

  fpm_dram_dev #(.ROW_W(RW), .ARR_RB(RB), .ARR_CB(CB)) u_fpm_dram_dev (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drv(input logic r, input logic u, input logic l, input logic w,
                     input logic o, input logic [3:0] a, input logic [15:0] d);
    ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o; addr = a; dq_in = d;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int r, input int c);
    return 16'((r * 4951) ^ (c * 773) ^ 16'h5AC3);
  endfunction

  task automatic open_row(input int r);
    drv(1, 1, 1, 1, 1, 0, 0);
    drv(0, 1, 1, 1, 1, 4'(r), 0);
    chk("R2 stb", rfsh_stb, 1);
    chk("R2 row", rfsh_row, r);
    chk("R2 kind", cyc_kind, 6);
  endtask

  task automatic close_row();
    drv(1, 1, 1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 kind", cyc_kind, 0);
    chk("R1 oe", dq_oe, 0);
    chk("R1 stb", rfsh_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) begin
        drv(0, 0, 0, 0, 1, 4'(c), pat(r, c));
        model[r*8+c] = pat(r, c);
        if (c == 0) chk("R3 write kind", cyc_kind, 2);
        else        chk("R6 page write kind", cyc_kind, 4);
        chk("R3 no drive on write", dq_oe, 0);
        drv(0, 1, 1, 1, 1, 0, 0);
      end
      close_row();
    end

    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) begin
        drv(0, 0, 0, 1, 0, 4'(c), 0);
        chk("R4 data", dq_out, model[r*8+c]);
        chk("R4 oe", dq_oe, 2'b11);
        if (c == 0) chk("R4 read kind", cyc_kind, 1);
        else        chk("R6 page read kind", cyc_kind, 3);
        drv(0, 1, 1, 1, 0, 0, 0);
        chk("R5 float on rise", dq_oe, 0);
      end
      close_row();
    end

    open_row(2);
    drv(0, 0, 1, 0, 1, 3, 16'hBEEF);
    model[2*8+3][15:8] = 8'hBE;
    drv(0, 1, 1, 1, 1, 0, 0);
    drv(0, 1, 0, 1, 0, 3, 0);
    chk("R5 upper lane floats", dq_oe, 2'b01);
    chk("R3 lower lane kept", dq_out[7:0], model[2*8+3][7:0]);
    drv(0, 1, 1, 1, 0, 0, 0);
    drv(0, 0, 0, 1, 0, 3, 0);
    chk("R3 byte write word", dq_out, model[2*8+3]);
    drv(0, 1, 1, 1, 0, 0, 0);
    close_row();

    open_row(5);
    drv(0, 0, 0, 1, 0, 1, 0);
    chk("R7 read phase", dq_out, model[5*8+1]);
    drv(0, 0, 0, 1, 1, 1, 0);
    chk("R4 oe high no drive", dq_oe, 0);
    drv(0, 0, 0, 0, 1, 1, 16'h1234);
    chk("R7 kind", cyc_kind, 5);
    model[5*8+1] = 16'h1234;
    drv(0, 1, 1, 1, 1, 0, 0);
    close_row();
    open_row(5);
    drv(0, 0, 0, 1, 0, 1, 0);
    chk("R7 written data", dq_out, 16'h1234);
    drv(0, 1, 1, 1, 1, 0, 0);
    close_row();

    open_row(9);
    close_row();
    chk("R9 kind after rise", cyc_kind, 6);

    for (int k = 0; k < 20; k++) begin
      drv(1, 0, 0, 1, 1, 4'(k), 0);
      drv(0, 0, 0, 1, 1, 4'(k), 0);
      chk("R8 stb", rfsh_stb, 1);
      if (k == 0) chk("R9 counter untouched", rfsh_row, exp_ref);
      else        chk("R8 counter row", rfsh_row, exp_ref);
      chk("R8 kind", cyc_kind, 7);
      chk("R8 no data", dq_oe, 0);
      exp_ref = (exp_ref + 1) % 16;
      drv(1, 0, 0, 1, 1, 0, 0);
      chk("R11 single pulse", rfsh_stb, 0);
      drv(1, 1, 1, 1, 1, 0, 0);
    end

    open_row(3);
    drv(0, 0, 0, 1, 0, 4, 0);
    chk("R10 read", dq_out, model[3*8+4]);
    drv(1, 0, 0, 1, 0, 0, 0);
    chk("R10 oe ras high", dq_oe, 2'b11);
    chk("R10 data ras high", dq_out, model[3*8+4]);
    drv(0, 0, 0, 1, 0, 0, 0);
    chk("R10 kind", cyc_kind, 7);
    chk("R10 counter row", rfsh_row, exp_ref);
    chk("R10 oe held", dq_oe, 2'b11);
    chk("R10 data held", dq_out, model[3*8+4]);
    exp_ref = (exp_ref + 1) % 16;
    drv(1, 0, 0, 1, 0, 0, 0);
    drv(1, 1, 1, 1, 1, 0, 0);
    chk("R5 float after hidden", dq_oe, 0);

    drv(1, 0, 0, 1, 1, 0, 0);
    drv(0, 0, 0, 1, 1, 0, 0);
    chk("R8 counter after hidden", rfsh_row, exp_ref);
    drv(1, 1, 1, 1, 1, 0, 0);

    open_row(0);
    for (int c = 0; c < 8; c++) begin
      drv(0, 0, 0, 1, 0, 4'(c), 0);
      chk("R8 refresh kept data", dq_out, model[c]);
      drv(0, 1, 1, 1, 0, 0, 0);
    end
    close_row();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule